// File: doc/BRIEF.md
# Serial Character Receiver with Error Status

This block receives asynchronous serial characters on one input line and stores them, each with its own error marks, in a 16-entry receive queue. An external strobe sets the sample rate. The strobe pulses 16 times per bit. The receiver locates the middle of the start bit, samples each later bit at its centre, and checks parity and stop bits. The character word length is 5 to 8 bits. Parity is optional and can be odd or even. One or two stop bits can be selected.

Software reaches the block through a small register bus. The bus has one-cycle registered read data. Reading the data register removes the oldest character. The error marks of that character are then merged into a sticky status register, which any write clears. Interrupt causes are kept in a separate sticky cause register, which any write also clears:

- a change on the clear-to-send input;
- a queue fill level at or above a programmable threshold;
- an idle receive line while characters are waiting.

The interrupt output is high whenever any cause bit is set.

Register addresses: 0 data, 1 status, 2 line format, 3 control, 4 flags, 5 interrupt cause, 6 receive threshold.

Top module: `serial_rx_port`

## Requirements
- R1: After reset, the block shows the following values: status reads 0, interrupt cause reads 0, control reads 0, threshold reads 1, flags read 0x10 with the clear-to-send input low, and the interrupt output is low.
- R2: With 8 data bits, no parity and one stop bit, each character is assembled least significant bit first and read back unchanged from the data register, in arrival order.
- R3: Line format bits [1:0] select the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the word length read as zero.
- R4: Line format bit 2 enables a parity bit and bit 3 selects even parity (clear means odd). A parity mismatch sets status bit 1 when that character is read from the data register.
- R5: A stop bit sampled low sets status bit 0 when that character is read. With line format bit 4 set, the second stop bit is checked as well.
- R6: A line held low for a whole frame, stop bits included, queues exactly one character of value 0x00 marked as break. Reading that character makes status read exactly 0x04. No further character is queued until the line returns high.
- R7: A character completing while 16 characters are queued is discarded and sets status bit 3. The 16 queued characters stay intact.
- R8: Any write to the status register clears all of its bits.
- R9: Flags bit 0 is the synchronised clear-to-send level, bit 4 is set when the queue is empty, and bit 6 is set when the queue holds 16 characters.
- R10: With control bit 4 set, interrupt cause bit 1 is set while the queue count is at least the threshold. The interrupt output follows the OR of the cause bits. Any write to the cause register clears them.
- R11: With control bit 3 set, any change on the clear-to-send input sets interrupt cause bit 0. With control bit 3 clear, a change sets nothing.
- R12: With control bit 6 set, cause bit 3 is set once the queue has been non-empty and the line idle for 32 bit-times. It stays clear before that.
- R13: With control bit 0 clear, the receive line is ignored and nothing is queued.
- R14: Reading the data register while the queue is empty returns 0 and leaves the flags and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Sample strobe, 16 pulses per bit |
| rx_in | input | 1 | Serial receive line, idle high |
| cts_in | input | 1 | Clear-to-send input |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the access |
| irq | output | 1 | Interrupt request |

## Verification
A misaligned bit counter or sample point shows up at the ports as shifted or wrongly sized data on the first character read after that frame. It can also appear as a false framing mark in the status read that follows the data read. Corrupted queue pointers show as wrong order or a wrong empty or full flag within a single sequence of 16 characters. A stuck break or idle-timer state is caught by the characters that follow, or by the cause register within about one frame or 32 bit-times.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_LINE = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_FLAG = 3'd4;
  localparam logic [2:0] A_CAUS = 3'd5;
  localparam logic [2:0] A_LVL  = 3'd6;

  localparam int C_EN   = 0;
  localparam int C_MSIE = 3;
  localparam int C_RXIE = 4;
  localparam int C_TOIE = 6;
  localparam logic [7:0] CTRL_MASK = 8'h79;

  typedef struct packed {
    logic              brk;
    logic              pe;
    logic              fe;
    logic [CHAR_W-1:0] data;
  } rx_char_t;
endpackage

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  output logic       push,
  output rx_char_t   chr,
  output logic       busy
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_WAITHI} st_e;

  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        bidx;
  logic [CHAR_W-1:0] shreg;
  logic              par_acc, all_zero, pe_r, fe_first;

  logic [3:0]        nbits;
  logic              samp, fin, fin_fe, fin_zero;
  logic [CHAR_W-1:0] aligned;

  always_comb begin
    nbits    = {2'b00, wlen} + 4'd5;
    samp     = tick && (cnt == LAST);
    fin      = samp && ((st == S_STOP1 && !two_stop) || st == S_STOP2);
    fin_fe   = !rx || (st == S_STOP2 && fe_first);
    fin_zero = all_zero && !rx;
    aligned  = shreg >> (4'd8 - nbits);
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      all_zero <= 1'b0;
      pe_r     <= 1'b0;
      fe_first <= 1'b0;
      push     <= 1'b0;
      chr      <= '0;
    end else begin
      push <= 1'b0;
      if (st == S_WAITHI) begin
        if (rx) st <= S_IDLE;
      end else if (tick) begin
        case (st)
          S_IDLE: if (!rx) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (rx) st <= S_IDLE;
              else begin
                st       <= S_DATA;
                bidx     <= '0;
                shreg    <= '0;
                par_acc  <= 1'b0;
                all_zero <= 1'b1;
                pe_r     <= 1'b0;
                fe_first <= 1'b0;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (samp) begin
              cnt      <= '0;
              shreg    <= {rx, shreg[CHAR_W-1:1]};
              par_acc  <= par_acc ^ rx;
              all_zero <= all_zero & !rx;
              if ({1'b0, bidx} == nbits - 4'd1) st <= par_en ? S_PAR : S_STOP1;
              else bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (samp) begin
              cnt      <= '0;
              pe_r     <= par_acc ^ rx ^ !par_even;
              all_zero <= all_zero & !rx;
              st       <= S_STOP1;
            end else cnt <= cnt + 1'b1;
          end
          default: begin
            if (samp) begin
              cnt <= '0;
              if (fin) begin
                push <= 1'b1;
                if (fin_zero) begin
                  chr <= '{brk: 1'b1, pe: 1'b0, fe: 1'b0, data: '0};
                  st  <= S_WAITHI;
                end else begin
                  chr <= '{brk: 1'b0, pe: pe_r, fe: fin_fe, data: aligned};
                  st  <= fin_fe ? S_WAITHI : S_IDLE;
                end
              end else begin
                fe_first <= !rx;
                all_zero <= all_zero & !rx;
                st       <= S_STOP2;
              end
            end else cnt <= cnt + 1'b1;
          end
        endcase
      end
    end
  end

  // R2
  push_pulse_chk: assert property (@(posedge clk) disable iff (rst) push |=> !push);
  // R6
  brk_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (push && chr.brk) |-> (chr.data == '0 && !chr.fe && !chr.pe));
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == (PTR_W+1)'(DEPTH));
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      count <= count + (PTR_W+1)'(do_wr) - (PTR_W+1)'(do_rd);
    end
  end

  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (PTR_W+1)'(DEPTH));
  // R14
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import uart_rx_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int OVS          = 16,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       rx_in,
  input  logic       cts_in,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int LVL_W  = $clog2(DEPTH) + 1;
  localparam int TO_LIM = TIMEOUT_BITS * OVS;
  localparam int TO_W   = $clog2(TO_LIM + 1);
  localparam int CW     = $bits(rx_char_t);

  logic [1:0]       rx_s, cts_s;
  logic             cts_d;
  logic [7:0]       ctrl;
  logic [4:0]       line;
  logic [LVL_W-1:0] lvl;
  logic [3:0]       status, status_n;
  logic [3:0]       cause, cause_n;
  logic [TO_W-1:0]  to_cnt;

  logic             eng_push, eng_busy;
  rx_char_t         eng_chr, head;
  logic [CW-1:0]    head_raw;
  logic [LVL_W-1:0] count;
  logic             empty, full;
  logic             wr, rd, pop_go, ovr_set, to_hit, cts_chg;

  assign wr      = bus_en && bus_we;
  assign rd      = bus_en && !bus_we;
  assign pop_go  = rd && bus_addr == A_DATA && !empty;
  assign ovr_set = eng_push && full;
  assign cts_chg = cts_s[1] ^ cts_d;
  assign head    = rx_char_t'(head_raw);
  assign to_hit  = baud_tick && !empty && !eng_busy && to_cnt == TO_W'(TO_LIM - 1);

  rx_frame_engine #(.OVS(OVS)) u_engine (
    .clk(clk), .rst(rst), .en(ctrl[C_EN]), .tick(baud_tick), .rx(rx_s[1]),
    .wlen(line[1:0]), .par_en(line[2]), .par_even(line[3]), .two_stop(line[4]),
    .push(eng_push), .chr(eng_chr), .busy(eng_busy)
  );

  rx_char_fifo #(.DEPTH(DEPTH), .W(CW)) u_fifo (
    .clk(clk), .rst(rst), .push(eng_push), .din(eng_chr), .pop(pop_go),
    .dout(head_raw), .count(count), .empty(empty), .full(full)
  );

  always_comb begin
    status_n = (wr && bus_addr == A_STAT) ? 4'h0 : status;
    if (pop_go) status_n[2:0] = status_n[2:0] | {head.brk, head.pe, head.fe};
    if (ovr_set) status_n[3] = 1'b1;

    cause_n = (wr && bus_addr == A_CAUS) ? 4'h0 : cause;
    if (cts_chg && ctrl[C_MSIE]) cause_n[0] = 1'b1;
    if (ctrl[C_RXIE] && !empty && count >= lvl) cause_n[1] = 1'b1;
    if (to_hit && ctrl[C_TOIE]) cause_n[3] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s   <= 2'b11;
      cts_s  <= 2'b00;
      cts_d  <= 1'b0;
      ctrl   <= '0;
      line   <= '0;
      lvl    <= LVL_W'(1);
      status <= '0;
      cause  <= '0;
      irq    <= 1'b0;
      to_cnt <= '0;
    end else begin
      rx_s   <= {rx_s[0], rx_in};
      cts_s  <= {cts_s[0], cts_in};
      cts_d  <= cts_s[1];
      status <= status_n;
      cause  <= cause_n;
      irq    <= |cause_n;
      if (empty || eng_busy) to_cnt <= '0;
      else if (baud_tick && to_cnt != TO_W'(TO_LIM)) to_cnt <= to_cnt + 1'b1;
      if (wr) begin
        case (bus_addr)
          A_LINE: line <= bus_wdata[4:0];
          A_CTRL: ctrl <= bus_wdata & CTRL_MASK;
          A_LVL:  lvl  <= bus_wdata[LVL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd) begin
      case (bus_addr)
        A_DATA:  bus_rdata <= empty ? 8'h00 : head.data;
        A_STAT:  bus_rdata <= {4'h0, status};
        A_LINE:  bus_rdata <= {3'b000, line};
        A_CTRL:  bus_rdata <= ctrl;
        A_FLAG:  bus_rdata <= {1'b0, full, 1'b0, empty, 3'b000, cts_s[1]};
        A_CAUS:  bus_rdata <= {4'h0, cause};
        A_LVL:   bus_rdata <= 8'(lvl);
        default: bus_rdata <= 8'h00;
      endcase
    end
  end

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_STAT && !ovr_set) |=> (status == 4'h0));
  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_push && full && !pop_go) |=> (status[3] && count == $past(count)));
  // R13
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl[C_EN] |=> !eng_push);
endmodule

// File: tb/serial_rx_port_bench.sv
module serial_rx_port_bench;
  localparam int BIT_CLK = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic       cts_in = 1'b0;
  logic       bus_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  serial_rx_port u_serial_rx_port (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_in(rx_in), .cts_in(cts_in),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic line_bit(input logic v);
    rx_in = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pen, input logic pb,
                      input logic s1, input bit two, input logic s2);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (pen) line_bit(pb);
    line_bit(s1);
    if (two) line_bit(s2);
    line_bit(1'b1);
  endtask

  task automatic send8(input logic [7:0] d);
    send(d, 8, 0, 1'b0, 1'b1, 0, 1'b1);
  endtask

  task automatic prep(input logic [7:0] line, input logic [7:0] ctrl);
    logic [7:0] v;
    wr_reg(3'd3, 8'h00);
    wr_reg(3'd2, line);
    rd_reg(3'd4, v);
    while (v[4] == 1'b0) begin
      rd_reg(3'd0, v);
      rd_reg(3'd4, v);
    end
    wr_reg(3'd1, 8'h00);
    wr_reg(3'd5, 8'h00);
    wr_reg(3'd3, ctrl);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(3'd1, v); check("R1 status", v, 8'h00);
    rd_reg(3'd5, v); check("R1 cause", v, 8'h00);
    rd_reg(3'd3, v); check("R1 ctrl", v, 8'h00);
    rd_reg(3'd6, v); check("R1 level", v, 8'h01);
    rd_reg(3'd4, v); check("R1 flags", v, 8'h10);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    logic [7:0] pat [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    prep(8'h03, 8'h01);
    foreach (pat[i]) send8(pat[i]);
    foreach (pat[i]) begin
      rd_reg(3'd0, v); check("R2 data order", v, pat[i]);
    end
    rd_reg(3'd1, v); check("R2 no errors", v, 8'h00);
  endtask

  task automatic t_wordlen();
    logic [7:0] v;
    prep(8'h00, 8'h01);
    send(8'hFB, 5, 0, 1'b0, 1'b1, 0, 1'b1);
    rd_reg(3'd0, v); check("R3 5-bit", v, 8'h1B);
    prep(8'h01, 8'h01);
    send(8'h2D, 6, 0, 1'b0, 1'b1, 0, 1'b1);
    rd_reg(3'd0, v); check("R3 6-bit", v, 8'h2D);
    prep(8'h02, 8'h01);
    send(8'hDA, 7, 0, 1'b0, 1'b1, 0, 1'b1);
    rd_reg(3'd0, v); check("R3 7-bit", v, 8'h5A);
  endtask

  task automatic t_parity();
    logic [7:0] v;
    prep(8'h0F, 8'h01);
    send(8'h37, 8, 1, ^8'h37, 1'b1, 0, 1'b1);
    rd_reg(3'd0, v); check("R4 even ok data", v, 8'h37);
    rd_reg(3'd1, v); check("R4 even ok status", v, 8'h00);
    send(8'h37, 8, 1, ~(^8'h37), 1'b1, 0, 1'b1);
    rd_reg(3'd1, v); check("R4 status before read", v, 8'h00);
    rd_reg(3'd0, v); check("R4 bad data", v, 8'h37);
    rd_reg(3'd1, v); check("R4 parity err", v, 8'h02);
    prep(8'h07, 8'h01);
    send(8'h01, 8, 1, 1'b0, 1'b1, 0, 1'b1);
    rd_reg(3'd0, v);
    rd_reg(3'd1, v); check("R4 odd ok", v, 8'h00);
  endtask

  task automatic t_framing();
    logic [7:0] v;
    prep(8'h03, 8'h01);
    send(8'h55, 8, 0, 1'b0, 1'b0, 0, 1'b1);
    rd_reg(3'd0, v); check("R5 data", v, 8'h55);
    rd_reg(3'd1, v); check("R5 framing", v, 8'h01);
    wr_reg(3'd1, 8'h5A);
    rd_reg(3'd1, v); check("R8 clear", v, 8'h00);
    prep(8'h13, 8'h01);
    send(8'h66, 8, 0, 1'b0, 1'b1, 1, 1'b0);
    rd_reg(3'd0, v); check("R5 two-stop data", v, 8'h66);
    rd_reg(3'd1, v); check("R5 second stop", v, 8'h01);
  endtask

  task automatic t_break();
    logic [7:0] v;
    prep(8'h03, 8'h01);
    @(negedge clk);
    rx_in = 1'b0;
    repeat (12 * BIT_CLK) @(negedge clk);
    rx_in = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    rd_reg(3'd0, v); check("R6 break byte", v, 8'h00);
    rd_reg(3'd1, v); check("R6 break status", v, 8'h04);
    rd_reg(3'd4, v); check("R6 single entry", v, 8'h10);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    prep(8'h03, 8'h01);
    for (int i = 0; i < 16; i++) send8(8'(i * 7 + 3));
    rd_reg(3'd4, v); check("R9 full flag", v, 8'h40);
    rd_reg(3'd1, v); check("R7 no overrun yet", v, 8'h00);
    send8(8'hEE);
    rd_reg(3'd1, v); check("R7 overrun", v, 8'h08);
    for (int i = 0; i < 16; i++) begin
      rd_reg(3'd0, v); check("R7 kept data", v, 8'(i * 7 + 3));
    end
    rd_reg(3'd4, v); check("R7 discarded", v, 8'h10);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    prep(8'h03, 8'h00);
    send8(8'h81);
    rd_reg(3'd4, v); check("R13 ignored", v, 8'h10);
  endtask

  task automatic t_cts();
    logic [7:0] v;
    prep(8'h03, 8'h09);
    cts_in = 1'b1;
    repeat (6) @(negedge clk);
    rd_reg(3'd5, v); check("R11 cause set", v, 8'h01);
    check("R10 irq high", {7'b0, irq}, 8'h01);
    rd_reg(3'd4, v); check("R9 cts flag", v, 8'h11);
    wr_reg(3'd5, 8'h00);
    check("R10 irq low", {7'b0, irq}, 8'h00);
    rd_reg(3'd5, v); check("R10 cleared", v, 8'h00);
    wr_reg(3'd3, 8'h01);
    cts_in = 1'b0;
    repeat (6) @(negedge clk);
    rd_reg(3'd5, v); check("R11 masked", v, 8'h00);
  endtask

  task automatic t_rxint();
    logic [7:0] v;
    prep(8'h03, 8'h11);
    wr_reg(3'd6, 8'h02);
    send8(8'h12);
    rd_reg(3'd5, v); check("R10 below level", v, 8'h00);
    check("R10 irq idle", {7'b0, irq}, 8'h00);
    send8(8'h34);
    rd_reg(3'd5, v); check("R10 at level", v, 8'h02);
    check("R10 irq", {7'b0, irq}, 8'h01);
    rd_reg(3'd0, v);
    rd_reg(3'd0, v);
    wr_reg(3'd5, 8'h00);
    rd_reg(3'd5, v); check("R10 after drain", v, 8'h00);
    wr_reg(3'd6, 8'h01);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    prep(8'h03, 8'h41);
    send8(8'h77);
    repeat (780) @(negedge clk);
    rd_reg(3'd5, v); check("R12 too early", v, 8'h00);
    repeat (400) @(negedge clk);
    rd_reg(3'd5, v); check("R12 timeout", v, 8'h08);
    rd_reg(3'd0, v); check("R12 data", v, 8'h77);
  endtask

  task automatic t_empty_read();
    logic [7:0] v;
    prep(8'h03, 8'h01);
    rd_reg(3'd0, v); check("R14 empty data", v, 8'h00);
    rd_reg(3'd4, v); check("R14 flags", v, 8'h10);
    rd_reg(3'd1, v); check("R14 status", v, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_wordlen();
    t_parity();
    t_framing();
    t_break();
    t_overrun();
    t_enable();
    t_cts();
    t_rxint();
    t_timeout();
    t_empty_read();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule